// File: doc/BRIEF.md
# Shared-Slave Arbiter with Idle Parking

This block decides, cycle by cycle, which of five bus masters is connected to a single shared slave port. Each master raises a request line for every beat of its access and flags the final beat of a burst on a separate last-beat line. The arbiter answers with a registered one-hot grant vector and a `connected` flag, which together can steer the slave-side multiplexer directly. A master that is already connected when it raises its request is served in that same cycle. A master that is not connected waits one cycle while the connection is made.

A 32-bit configuration word controls two things. The first is a slot limit: the number of beats an owner may keep the slave while another master is waiting. The second is an idle policy, which decides what happens when an access ends and nobody else is asking. The slave can be dropped entirely, left on the master that used it last, or moved to a fixed master named by an index field. Parking removes the connect cycle for the master the slave is parked on, at the cost of that penalty for everyone else.

Contention is settled round-robin, starting with the master after the previous owner. All control pins are plain levels; no data passes through the block, so there is no valid/ready handshake.

Top module: `parking_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant` is 0 and `connected` is 0.
- R2: `grant` has at most one bit set, and `connected` is 1 exactly when `grant` is non-zero. When several masters compete for a free slave, the grant goes to the first requester at or after index previous-owner+1, counting upward modulo 5.
- R3: An owner that keeps its request high without signalling its last beat keeps the grant for as long as no other master requests, whatever the slot limit.
- R4: A master whose request rises while the slave is disconnected, or parked on a different master, sees its grant bit low in that cycle and high in the next, if no one else competes.
- R5: Idle policy 0 (`cfg_word[17:16]`=0): after a cycle in which the access ends and no other master requests, `connected` is 0.
- R6: Idle policy 1: after a cycle with no requests, the grant stays on the master that held it, and that master's next request is served in the cycle it is raised.
- R7: Idle policy 2 with fixed index `cfg_word[20:18]` in the range 0..4: after a cycle with no requests, `grant` equals 1 shifted left by that index.
- R8: Idle policy 3, or policy 2 with an index of 5 to 7, behaves as policy 0: after a cycle with no requests, `connected` is 0.
- R9: With slot limit L=`cfg_word[7:0]` non-zero, an owner whose request stays high while another master requests keeps the grant for exactly L cycles, and the competitor is granted in the next cycle.
- R10: A slot limit of 0 never pre-empts: a requesting owner without a last beat keeps the grant even while others request.
- R11: When the owner signals its last beat (request and last both high) and another master requests, the grant passes in the next cycle to a master other than the owner.
- R12: The slot count restarts on every new grant, so a master that takes over after a pre-emption also gets a full L cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Per-master request, high on every beat of an access |
| last | input | 5 | Per-master last-beat flag, meaningful with the master's request |
| cfg_word | input | 32 | Slot limit in bits 7..0, idle policy in 17..16, fixed index in 20..18 |
| grant | output | 5 | One-hot owner of the slave port, 0 when disconnected |
| connected | output | 1 | High while the slave is connected to some master |

## Verification
The checker covers the invariants that hold on every cycle. These are the one-hot grant and its agreement with `connected`, and an undisturbed owner keeping the slave. With a slot limit of 0 the owner is never displaced, and a last beat under contention hands the slave to another master. After a request-free cycle, each idle policy must also produce its own outcome. Only the bench scenarios can show the counted behaviour: the exact L-cycle slot tenure for both owner and successor, the one-cycle connect penalty against a parked or empty port, and the round-robin order across five busy masters. A cycle-level reference model derived from the requirements is compared against the outputs through a sweep of policy, index and slot-limit values under pseudo-random traffic.

// File: rtl/parking_arb_pkg.sv
package parking_arb_pkg;

  // Field placement inside the configuration word
  localparam int SLOT_LSB = 0;
  localparam int SLOT_W   = 8;
  localparam int POL_LSB  = 16;
  localparam int POL_W    = 2;
  localparam int PARK_LSB = 18;
  localparam int PARK_W   = 3;

  typedef enum logic [POL_W-1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_pol_e;

endpackage

// File: rtl/parking_arb_cfg.sv
module parking_arb_cfg
  import parking_arb_pkg::*;
#(
  parameter int N_MST = 5,
  parameter int CFG_W = 32,
  parameter int IDX_W = $clog2(N_MST)
) (
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [SLOT_W-1:0] slot_lim,
  output park_pol_e         pol_eff,
  output logic [IDX_W-1:0]  park_idx
);

  logic [PARK_W-1:0] park_raw;
  logic [POL_W-1:0]  pol_raw;
  logic              park_ok;

  assign slot_lim = cfg_word[SLOT_LSB +: SLOT_W];
  assign pol_raw  = cfg_word[POL_LSB +: POL_W];
  assign park_raw = cfg_word[PARK_LSB +: PARK_W];
  assign park_ok  = 32'(park_raw) < N_MST;
  assign park_idx = IDX_W'(park_raw);

  // Reserved policy and an out-of-range fixed index both fold to "no parking"
  always_comb begin
    unique case (pol_raw)
      2'd1:    pol_eff = PARK_LAST;
      2'd2:    pol_eff = park_ok ? PARK_FIXED : PARK_NONE;
      default: pol_eff = PARK_NONE;
    endcase
  end

endmodule

// File: rtl/parking_arb_rr.sv
module parking_arb_rr #(
  parameter int N_MST = 5,
  parameter int IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] cand,
  input  logic [IDX_W-1:0] prev,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  // Walk from farthest to nearest so the nearest candidate after prev wins
  always_comb begin
    found = 1'b0;
    pick  = prev;
    for (int k = N_MST; k >= 1; k--) begin
      int j;
      j = int'(prev) + k;
      if (j >= N_MST) j = j - N_MST;
      if (cand[IDX_W'(j)]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/parking_arb_slot.sv
module parking_arb_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] lim,
  output logic             at_limit
);

  logic [CNT_W-1:0] beats_q;
  logic [CNT_W:0]   beats_next;

  always_ff @(posedge clk) begin
    if (!rst_n)
      beats_q <= '0;
    else if (reload)
      beats_q <= '0;
    else if (tick && (beats_q != '1))
      beats_q <= beats_q + CNT_W'(1);
  end

  // True when the beat being served now is the lim-th of this tenure
  assign beats_next = {1'b0, beats_q} + (CNT_W+1)'(1);
  assign at_limit   = (lim != '0) && (beats_next >= {1'b0, lim});

endmodule

// File: rtl/parking_arbiter.sv
module parking_arbiter
  import parking_arb_pkg::*;
#(
  parameter int N_MST = 5,
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req,
  input  logic [N_MST-1:0] last,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [N_MST-1:0] grant,
  output logic             connected
);

  localparam int IDX_W = $clog2(N_MST);

  logic              conn_q, conn_d;
  logic [IDX_W-1:0]  own_q, own_d;
  logic [N_MST-1:0]  own_oh;
  logic [SLOT_W-1:0] slot_lim;
  park_pol_e         pol_eff;
  logic [IDX_W-1:0]  park_idx;
  logic              tick, preempt, redecide, at_limit, found;
  logic [N_MST-1:0]  cand;
  logic [IDX_W-1:0]  pick;

  parking_arb_cfg #(.N_MST(N_MST), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_cfg (
    .cfg_word (cfg_word),
    .slot_lim (slot_lim),
    .pol_eff  (pol_eff),
    .park_idx (park_idx)
  );

  for (genvar i = 0; i < N_MST; i++) begin : g_oh
    assign own_oh[i] = (own_q == IDX_W'(i));
  end

  // A beat is served when the connected master is requesting
  assign tick     = conn_q && req[own_q];
  assign cand     = tick ? (req & ~own_oh) : req;
  assign preempt  = tick && at_limit && (cand != '0);
  assign redecide = !tick || last[own_q] || preempt;

  parking_arb_slot #(.CNT_W(SLOT_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reload   (redecide),
    .lim      (slot_lim),
    .at_limit (at_limit)
  );

  parking_arb_rr #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rr (
    .cand  (cand),
    .prev  (own_q),
    .found (found),
    .pick  (pick)
  );

  always_comb begin
    conn_d = conn_q;
    own_d  = own_q;
    if (redecide) begin
      if (found) begin
        conn_d = 1'b1;
        own_d  = pick;
      end else begin
        unique case (pol_eff)
          PARK_LAST:  ;
          PARK_FIXED: begin
            conn_d = 1'b1;
            own_d  = park_idx;
          end
          default:    conn_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      own_q  <= '0;
    end else begin
      conn_q <= conn_d;
      own_q  <= own_d;
    end
  end

  assign grant     = conn_q ? own_oh : '0;
  assign connected = conn_q;

endmodule

// File: rtl/parking_arbiter_chk.sv
module parking_arbiter_chk
  import parking_arb_pkg::*;
#(
  parameter int N_MST = 5,
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req,
  input logic [N_MST-1:0] last,
  input logic [CFG_W-1:0] cfg_word,
  input logic [N_MST-1:0] grant,
  input logic             connected
);

  logic [POL_W-1:0]  pol;
  logic [PARK_W-1:0] pidx;
  logic [SLOT_W-1:0] lim;
  logic              idle, owner_busy, rivals;

  assign pol        = cfg_word[POL_LSB +: POL_W];
  assign pidx       = cfg_word[PARK_LSB +: PARK_W];
  assign lim        = cfg_word[SLOT_LSB +: SLOT_W];
  assign idle       = (req == '0);
  assign owner_busy = ((grant & req & ~last) != '0);
  assign rivals     = ((req & ~grant) != '0);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (connected == (grant != '0)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    owner_busy && !rivals |=> $stable(grant));

  p_idle_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (pol == 2'd0) |=> !connected);

  p_idle_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (pol == 2'd1) |=> $stable(grant));

  p_idle_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (pol == 2'd2) && (32'(pidx) < N_MST)
    |=> grant == (N_MST'(1) << $past(pidx)));

  p_idle_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle && ((pol == 2'd3) || ((pol == 2'd2) && (32'(pidx) >= N_MST)))
    |=> !connected);

  p_no_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0) && owner_busy |=> $stable(grant));

  p_handover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & req & last) != '0) && rivals
    |=> connected && ((grant & $past(grant)) == '0));

endmodule

bind parking_arbiter parking_arbiter_chk #(.N_MST(N_MST), .CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .last      (last),
  .cfg_word  (cfg_word),
  .grant     (grant),
  .connected (connected)
);

// File: tb/sim_parking_arbiter.sv
module sim_parking_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req = '0;
  logic [4:0]  last = '0;
  logic [31:0] cfg = '0;
  logic [4:0]  grant;
  logic        connected;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // Reference state, advanced at each input drive
  bit m_conn = 1'b0;
  int m_own  = 0;
  int m_cnt  = 0;

  parking_arbiter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .last      (last),
    .cfg_word  (cfg),
    .grant     (grant),
    .connected (connected)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mkcfg(int lim, int pol, int idx);
    return {11'd0, 3'(idx), 2'(pol), 8'd0, 8'(lim)};
  endfunction

  function automatic logic [4:0] m_grant();
    return m_conn ? (5'b1 << m_own) : 5'b0;
  endfunction

  task automatic chk(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s grant/conn got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic want(logic [4:0] g, string t);
    chk((grant == g) && (connected == (g != 5'b0)), t, int'({connected, grant}),
        int'({g != 5'b0, g}));
  endtask

  task automatic model_step(logic [4:0] r, logic [4:0] l, logic [31:0] c);
    int lim, pol, idx, nxt;
    bit tk, pre, rd, fnd;
    logic [4:0] cnd;
    lim = int'(c[7:0]);
    pol = int'(c[17:16]);
    idx = int'(c[20:18]);
    tk  = m_conn && r[m_own];
    cnd = r;
    if (tk) cnd[m_own] = 1'b0;
    pre = tk && (lim != 0) && (m_cnt + 1 >= lim) && (cnd != 5'b0);
    rd  = !tk || l[m_own] || pre;
    if (!rd) begin
      if (m_cnt < 255) m_cnt++;
    end else begin
      m_cnt = 0;
      fnd = 1'b0;
      nxt = 0;
      for (int k = 1; k <= 5; k++) begin
        int j;
        j = (m_own + k) % 5;
        if (!fnd && cnd[j]) begin
          fnd = 1'b1;
          nxt = j;
        end
      end
      if (fnd) begin
        m_conn = 1'b1;
        m_own  = nxt;
      end else if (pol == 1) begin
        m_conn = m_conn;
      end else if (pol == 2 && idx <= 4) begin
        m_conn = 1'b1;
        m_own  = idx;
      end else begin
        m_conn = 1'b0;
      end
    end
  endtask

  // Drive one cycle of inputs, let the edge pass, compare with the model
  task automatic cyc(logic [4:0] r, logic [4:0] l);
    req  = r;
    last = l;
    model_step(r, l, cfg);
    @(negedge clk);
    want(m_grant(), tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired, got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [4:0]  prev_g;
    int          gi;

    repeat (3) @(negedge clk);
    want(5'b0, "R1");
    rst_n = 1'b1;
    want(5'b0, "R1");

    // Policy 0: connect penalty, then disconnect after the access ends
    tag = "R4";
    cfg = mkcfg(0, 0, 0);
    cyc(5'b0, 5'b0);
    want(5'b0, "R4");
    cyc(5'b00100, 5'b0);
    want(5'b00100, "R4");
    cyc(5'b00100, 5'b0);
    tag = "R5";
    cyc(5'b00100, 5'b00100);
    want(5'b0, "R5");
    cyc(5'b0, 5'b0);
    want(5'b0, "R5");

    // Policy 1: park on the last owner, no penalty for it
    tag = "R6";
    cfg = mkcfg(0, 1, 0);
    cyc(5'b00010, 5'b0);
    cyc(5'b00010, 5'b00010);
    want(5'b00010, "R6");
    cyc(5'b0, 5'b0);
    cyc(5'b0, 5'b0);
    want(5'b00010, "R6");
    cyc(5'b00010, 5'b0);
    want(5'b00010, "R6");
    tag = "R4";
    cyc(5'b01000, 5'b0);
    want(5'b01000, "R4");

    // Policy 2: park on the fixed index
    tag = "R7";
    cfg = mkcfg(0, 2, 4);
    cyc(5'b01000, 5'b01000);
    want(5'b10000, "R7");
    cyc(5'b10000, 5'b0);
    want(5'b10000, "R7");

    // Sweep every policy and index over idle cycles
    for (int p = 0; p < 4; p++) begin
      for (int x = 0; x < 8; x++) begin
        prev_g = grant;
        cfg = mkcfg(0, p, x);
        tag = (p == 0) ? "R5" : (p == 1) ? "R6" : (p == 2 && x <= 4) ? "R7" : "R8";
        cyc(5'b0, 5'b0);
        cyc(5'b0, 5'b0);
        if (p == 1)               want(prev_g, tag);
        else if (p == 2 && x <= 4) want(5'b1 << x, tag);
        else                       want(5'b0, tag);
      end
    end

    // Slot limit: owner and successor each get exactly L cycles
    for (int L = 1; L <= 4; L++) begin
      cfg = mkcfg(L, 0, 0);
      tag = "R9";
      cyc(5'b0, 5'b0);
      cyc(5'b00001, 5'b0);
      for (int k = 0; k < L; k++) begin
        want(5'b00001, "R9");
        cyc(5'b01001, 5'b0);
      end
      tag = "R12";
      for (int k = 0; k < L; k++) begin
        want(5'b01000, "R12");
        cyc(5'b01001, 5'b0);
      end
      want(5'b00001, "R12");
      cyc(5'b0, 5'b0);
    end

    // No competitor: the limit does not matter
    tag = "R3";
    cfg = mkcfg(3, 0, 0);
    cyc(5'b00001, 5'b0);
    for (int k = 0; k < 12; k++) begin
      cyc(5'b00001, 5'b0);
      want(5'b00001, "R3");
    end

    // Limit 0: competitor never breaks in, until the last beat
    tag = "R10";
    cfg = mkcfg(0, 0, 0);
    for (int k = 0; k < 30; k++) begin
      cyc(5'b01001, 5'b0);
      want(5'b00001, "R10");
    end
    tag = "R11";
    cyc(5'b01001, 5'b00001);
    want(5'b01000, "R11");
    cyc(5'b0, 5'b0);

    // Round-robin with all five issuing single-beat accesses
    tag = "R2";
    cyc(5'b11111, 5'b11111);
    for (int k = 0; k < 12; k++) begin
      gi = 0;
      for (int b = 0; b < 5; b++) if (grant[b]) gi = b;
      cyc(5'b11111, 5'b11111);
      want(5'b1 << ((gi + 1) % 5), "R2");
    end
    cyc(5'b0, 5'b0);

    // Pseudo-random traffic over a grid of configurations
    lfsr = 32'hACE1_1234;
    foreach (lfsr[i]) ;
    for (int p = 0; p < 4; p++) begin
      for (int xi = 0; xi < 3; xi++) begin
        for (int li = 0; li < 4; li++) begin
          cfg = mkcfg((li == 3) ? 5 : li, p, (xi == 0) ? 1 : (xi == 1) ? 4 : 6);
          tag = "R2";
          for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[4:0] | lfsr[9:5], lfsr[14:10] & lfsr[19:15]);
          end
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule